// File: doc/BRIEF.md
# Bit-Serial Configurable-Sign Multiplier

This block multiplies two N-bit operands while using only N arithmetic cells. The multiplier operand B is captured in parallel when a start pulse arrives. The multiplicand A is then streamed in one bit per clock, least significant bit first. Each cell owns one bit of B and holds a full adder with registered sum and carry. Partial sums ripple one cell towards bit 0 on every clock. The product leaves as a serial stream of 2N bits, least significant bit first. A one-cycle done flag follows the last bit.

A mode input chosen at start selects unsigned or two's complement operands. At start, a set of per-step control lanes is loaded into an internal shift register that is 2N steps long, and one step is consumed per clock alongside the A bits. The lanes gate A into the array and choose which partial products are inverted. They also inject the two constant ones that the modified Baugh-Wooley formulation adds. Because of this, signed operands need no sign extension and the same cell row serves both modes. For the last N steps, A is replaced by zero so that the stored sums and carries flush out.

Top module: `sp_bw_mult`

## Requirements
- R1: During a synchronous active-low reset and in the cycle after it, p_valid and done are 0.
- R2: With tc_mode=0 at start, the 2N collected output bits equal the unsigned product of A and B.
- R3: With tc_mode=1 at start, the 2N collected output bits equal the two's complement product of A and B as a 2N-bit value. This includes the most negative operand times itself, minus one times minus one, and the most negative times the most positive.
- R4: A start is accepted in cycle C. In cycles C+1 to C+N, a_ser carries A bit 0 to bit N-1, one bit per cycle. p_valid is then high for exactly 2N consecutive cycles beginning at C+2, and p_ser carries product bit k in the k-th of those cycles, counting from 0.
- R5: done is high for exactly one cycle: the cycle right after the last valid product bit. It is never high together with p_valid.
- R6: A start raised while a multiplication is in progress (from the accepting edge up to, but not including, the done cycle) is ignored. The running product and its bit count are unchanged.
- R7: a_ser is ignored in every cycle after the N cycles that carry A.
- R8: b_in and tc_mode are sampled only at the accepted start. Changing them afterwards does not alter the product.
- R9: A start raised in the done cycle is accepted and begins a new multiplication with the timing of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse; accepted only when idle or in the done cycle |
| tc_mode | input | 1 | 1 = two's complement operands, 0 = unsigned; sampled at start |
| b_in | input | N | Multiplier operand, sampled at start |
| a_ser | input | 1 | Multiplicand bit stream, LSB first, in the N cycles after start |
| p_ser | output | 1 | Product bit stream, LSB first |
| p_valid | output | 1 | p_ser holds a product bit |
| done | output | 1 | One-cycle pulse after the last product bit |

## Verification
A wrong sum or carry in any cell shows up as a wrong product bit at or above that cell's weight. The error appears at most N clocks later, so it is caught by the product comparison in the done cycle. A control lane that is shifted one step off, or loaded with the wrong mode, corrupts the high half of signed products while unsigned products stay intact. For this reason the corner operands are run in both modes. A fault in the step counter or the busy logic changes the number of valid bits, or where they fall relative to start. The bench catches this at the first valid bit, and the bound checker catches it at done.

// File: rtl/sp_bw_pkg.sv
// Shared types for the bit-serial multiplier.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package sp_bw_pkg;

    // Control applied to the cell row during one step.
    typedef struct packed {
        logic a_gate;  // pass the A bit into the array
        logic inv_hi;  // invert the partial product of the top cell
        logic inv_lo;  // invert the partial products of all lower cells
        logic k_one;   // inject a constant one into the top cell
    } step_ctl_t;

endpackage

// File: rtl/sp_bw_cell.sv
// One array cell: a full adder whose sum and carry are registered.
// Assumes clr and en are never both relevant at once; clr has priority.
module sp_bw_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic pp,
    input  logic s_in,
    output logic s_q
);
    logic c_q;
    logic s_d;
    logic c_d;

    // Full-adder combination of partial product, incoming sum and own carry.
    always_comb begin
        s_d = pp ^ s_in ^ c_q;
        c_d = (pp & s_in) | (pp & c_q) | (s_in & c_q);
    end

    // Sum and carry storage with clear at the start of a multiplication.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s_q <= 1'b0;
            c_q <= 1'b0;
        end else if (en) begin
            s_q <= s_d;
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/sp_bw_ctlseq.sv
// Control-vector shift register: 2N steps of per-step sign handling.
// Loaded from the mode at start and shifted one step per active clock.
// Assumes N >= 2, so that the two constant injections use distinct steps.
module sp_bw_ctlseq
    import sp_bw_pkg::*;
#(
    parameter int N = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      shift,
    input  logic      tc_mode,
    output step_ctl_t cur
);
    localparam int STEPS = 2 * N;

    logic [STEPS-1:0] gate_q, hi_q, lo_q, k_q;
    logic [STEPS-1:0] gate_d, hi_d, lo_d, k_d;

    // Initial lane contents for the selected number representation.
    always_comb begin
        for (int t = 0; t < STEPS; t++) begin
            gate_d[t] = (t < N);
            hi_d[t]   = tc_mode && (t < N - 1);
            lo_d[t]   = tc_mode && (t == N - 1);
            k_d[t]    = tc_mode && (t == 1 || t == N);
        end
    end

    // Lane storage: load at start, then step toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            k_q    <= '0;
        end else if (load) begin
            gate_q <= gate_d;
            hi_q   <= hi_d;
            lo_q   <= lo_d;
            k_q    <= k_d;
        end else if (shift) begin
            gate_q <= gate_q >> 1;
            hi_q   <= hi_q >> 1;
            lo_q   <= lo_q >> 1;
            k_q    <= k_q >> 1;
        end
    end

    // Current step control is the bottom bit of each lane.
    always_comb begin
        cur.a_gate = gate_q[0];
        cur.inv_hi = hi_q[0];
        cur.inv_lo = lo_q[0];
        cur.k_one  = k_q[0];
    end
endmodule

// File: rtl/sp_bw_mult.sv
// Serial-parallel modified Baugh-Wooley multiplier, N x N -> 2N bits.
// B is held in parallel and A arrives LSB first over N cycles.
// The product leaves LSB first over 2N cycles, followed by a done pulse.
// Assumes N >= 2. A start while busy is ignored; a start in the done cycle is accepted.
module sp_bw_mult
    import sp_bw_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tc_mode,
    input  logic [N-1:0] b_in,
    input  logic         a_ser,
    output logic         p_ser,
    output logic         p_valid,
    output logic         done
);
    localparam int STEPS = 2 * N;
    localparam int CW    = $clog2(STEPS + 1);

    logic          busy;
    logic [CW-1:0] step_q;
    logic [N-1:0]  b_q;
    logic          accept;
    logic          run;
    logic          a_eff;
    logic [N:0]    s_vec;
    step_ctl_t     cur;

    assign accept = start && !busy;
    assign run    = busy && (step_q < CW'(STEPS));
    assign a_eff  = a_ser && cur.a_gate;

    // Sequencing of steps, operand capture, output valid and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            step_q  <= '0;
            b_q     <= '0;
            p_valid <= 1'b0;
            done    <= 1'b0;
        end else if (accept) begin
            busy    <= 1'b1;
            step_q  <= '0;
            b_q     <= b_in;
            p_valid <= 1'b0;
            done    <= 1'b0;
        end else if (run) begin
            step_q  <= step_q + 1'b1;
            p_valid <= 1'b1;
            done    <= 1'b0;
        end else if (busy) begin
            busy    <= 1'b0;
            p_valid <= 1'b0;
            done    <= 1'b1;
        end else begin
            p_valid <= 1'b0;
            done    <= 1'b0;
        end
    end

    sp_bw_ctlseq #(.N(N)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (run),
        .tc_mode (tc_mode),
        .cur     (cur)
    );

    assign s_vec[N] = cur.k_one;

    // Cell row: cell i handles bit i of B; its sum feeds cell i-1.
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic pp;
        logic inv;
        if (i == N - 1) begin : g_top
            assign inv = cur.inv_hi;
        end else begin : g_low
            assign inv = cur.inv_lo;
        end
        assign pp = (a_eff & b_q[i]) ^ inv;

        sp_bw_cell i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (accept),
            .en    (run),
            .pp    (pp),
            .s_in  (s_vec[i+1]),
            .s_q   (s_vec[i])
        );
    end

    assign p_ser = s_vec[0];
endmodule

// File: rtl/sp_bw_mult_chk.sv
// Port-level protocol checker for sp_bw_mult, bound to every instance.
// Counts valid bits between done pulses to check the window length.
module sp_bw_mult_chk #(
    parameter int N = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic p_valid,
    input logic done
);
    localparam int VW = $clog2(2 * N + 1) + 1;

    logic [VW-1:0] vcnt;

    // Number of valid product bits since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || done) vcnt <= '0;
        else if (p_valid)   vcnt <= vcnt + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!p_valid && !done));

    p_bit_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt == VW'(2 * N)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(p_valid));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && p_valid));

    p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (vcnt < VW'(2 * N)));

    p_start_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && p_valid && vcnt < VW'(2 * N - 1)) |=> p_valid);
endmodule

bind sp_bw_mult sp_bw_mult_chk #(.N(N)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .p_valid (p_valid),
    .done    (done)
);

// File: tb/test_sp_bw_mult.sv
module test_sp_bw_mult;
    localparam int N = 8;

    typedef struct {
        logic [2*N-1:0] exp;
        int             start_cyc;
        string          tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         tc_mode = 1'b0;
    logic [N-1:0] b_in = '0;
    logic         a_ser = 1'b0;
    logic         p_ser;
    logic         p_valid;
    logic         done;

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    bit     finished = 1'b0;
    item_t  sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sp_bw_mult #(.N(N)) i_sp_bw_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tc_mode (tc_mode),
        .b_in    (b_in),
        .a_ser   (a_ser),
        .p_ser   (p_ser),
        .p_valid (p_valid),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b, input bit tc);
        logic [2*N-1:0] xa, xb;
        xa = tc ? {{N{a[N-1]}}, a} : {{N{1'b0}}, a};
        xb = tc ? {{N{b[N-1]}}, b} : {{N{1'b0}}, b};
        return xa * xb;
    endfunction

    // Monitor: collects serial bits and compares at done.
    logic [2*N-1:0] acc;
    int             nbits = 0;
    bit             prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (p_valid) begin
                if (nbits == 0 && sb.size() > 0)
                    check(cyc == sb[0].start_cyc + 2, "R4 first bit cycle",
                          64'(cyc), 64'(sb[0].start_cyc + 2));
                if (nbits < 2 * N) acc[nbits] = p_ser;
                nbits++;
            end
            if (done) begin
                check(!p_valid, "R5 done with valid", 64'(p_valid), 64'd0);
                check(prev_valid, "R5 done after last bit", 64'(prev_valid), 64'd1);
                check(nbits == 2 * N, "R4 bit count", 64'(nbits), 64'(2 * N));
                if (sb.size() > 0) begin
                    item_t it;
                    it = sb.pop_front();
                    check(acc == it.exp, it.tag, 64'(acc), 64'(it.exp));
                end else begin
                    check(1'b0, "R6 unexpected done", 64'd1, 64'd0);
                end
                nbits = 0;
            end
            prev_valid = p_valid;
        end
    end

    // Driver: starts a multiplication at the current negedge, returns in the done cycle.
    task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input bit tc,
                       input string tag, input bit junk, input bit restart);
        item_t it;
        int    k;
        it.exp = ref_prod(a, b, tc);
        it.start_cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
        start = 1'b1; b_in = b; tc_mode = tc;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            start = 1'b0;
            a_ser = a[i];
            if (junk) begin b_in = N'($urandom); tc_mode = 1'($urandom); end
        end
        k = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            a_ser = junk ? 1'($urandom) : 1'b0;
            if (junk) begin b_in = N'($urandom); tc_mode = 1'($urandom); end
            if (restart && (k == 2 || k == N)) start = 1'b1;
            k++;
        end
        a_ser = 1'b0;
    endtask

    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] ONES = {N{1'b1}};

    initial begin
        repeat (3) @(negedge clk);
        check(!p_valid && !done, "R1 outputs in reset", 64'({p_valid, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!p_valid && !done, "R1 outputs after reset", 64'({p_valid, done}), 64'd0);

        run(8'd0,  8'd0,  1'b0, "R2 zero",        1'b0, 1'b0); @(negedge clk);
        run(ONES,  ONES,  1'b0, "R2 max unsigned",1'b0, 1'b0); @(negedge clk);
        run(8'd13, 8'd11, 1'b0, "R2 small",       1'b0, 1'b0); @(negedge clk);
        run(MINV,  MINV,  1'b1, "R3 min*min",     1'b0, 1'b0); @(negedge clk);
        run(ONES,  ONES,  1'b1, "R3 -1*-1",       1'b0, 1'b0); @(negedge clk);
        run(MINV,  MAXV,  1'b1, "R3 min*max",     1'b0, 1'b0); @(negedge clk);
        run(8'd1,  ONES,  1'b1, "R3 1*-1",        1'b0, 1'b0); @(negedge clk);
        run(8'hA5, 8'h3C, 1'b1, "R7 R8 junk inputs signed",   1'b1, 1'b0); @(negedge clk);
        run(8'hA5, 8'h3C, 1'b0, "R7 R8 junk inputs unsigned", 1'b1, 1'b0); @(negedge clk);
        run(8'h77, 8'h9E, 1'b1, "R6 start while busy",        1'b0, 1'b1); @(negedge clk);
        run(8'h2B, 8'hF0, 1'b0, "R9 first of pair",  1'b0, 1'b0);
        run(8'hC3, 8'h81, 1'b1, "R9 back-to-back",   1'b0, 1'b0); @(negedge clk);
        for (int r = 0; r < 40; r++) begin
            logic [N-1:0] ra, rb;
            bit tc;
            ra = N'($urandom); rb = N'($urandom); tc = 1'($urandom);
            run(ra, rb, tc, tc ? "R3 random signed" : "R2 random unsigned", 1'($urandom), 1'($urandom));
            if (r % 3 != 0) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R6 pending results", 64'(sb.size()), 64'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule